// File: doc/BRIEF.md
# Seven-Operand Carry-Save Adder Tree

This block adds seven unsigned operands in one pass of combinational logic. The block has no clock and no registers. The operands first go through four levels of 3:2 compressors. Each compressor takes three vectors and returns a partial-sum vector and a carry vector, with the carry vector weighted one place higher. The levels form a Wallace arrangement of five compressor rows, which reduces the seven inputs to two vectors. A single ripple carry-propagate adder then combines those two vectors into the final total.

The output is wide enough to hold the largest possible total, so it never wraps. With 8-bit operands the largest total is 7 × 255 = 1785, which fits in 11 bits. Inside the tree, every vector is carried at the full output width, so no carry bit is dropped between levels. The block fits where many values must be summed in one step, such as a reduction stage of a dot product.

Top module: `csa7_tree`

## Requirements
- R1: For any operands, `sum_o` equals the arithmetic sum of the seven unsigned operands `opa_i` .. `opg_i`.
- R2: When every operand is all ones (255), `sum_o` is 1785 (11'h6F9).
- R3: The total never overflows. The final adder's carry-out is 0, and no compressor row produces a carry above bit OPW+2.
- R4: Each compressor row conserves value. For its three inputs x, y, z it returns s = x^y^z and c = (majority of x, y, z) shifted left one place, and s + c = x + y + z.
- R5: When all operands are zero, `sum_o` is zero.
- R6: When exactly one operand is nonzero, `sum_o` equals that operand, whichever of the seven positions holds it.
- R7: When only three operands are nonzero, `sum_o` equals their sum. This holds for both the three-operand group that shares a first-level row and a group spread across rows.
- R8: The block is purely combinational. A change on any operand reaches `sum_o` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | OPW (8) | Operand A, unsigned |
| opb_i | input | OPW (8) | Operand B, unsigned |
| opc_i | input | OPW (8) | Operand C, unsigned |
| opd_i | input | OPW (8) | Operand D, unsigned |
| ope_i | input | OPW (8) | Operand E, unsigned |
| opf_i | input | OPW (8) | Operand F, unsigned |
| opg_i | input | OPW (8) | Operand G, unsigned; enters the tree at the last compressor row |
| sum_o | output | OPW+3 (11) | Full-precision total of the seven operands |

## Verification
The hardest condition to reach from the ports is a carry that must travel through every compressor level and then the whole ripple chain. Random operands rarely produce this. The stimulus reaches it in three ways: all operands at 255, operand patterns near the top of the range with alternating bits, and single-operand sweeps at each position. The single-operand sweeps show that each input is wired at its correct weight, including operand G, which skips the first three levels.

// File: rtl/csa7_pkg.sv
package csa7_pkg;
    // Default operand width; the sum width adds three bits for seven operands.
    localparam int unsigned OPW_DEF   = 8;
    localparam int unsigned N_OPS     = 7;
    localparam int unsigned N_ROWS    = 5;
    localparam int unsigned GROWTH    = 3;   // ceil(log2(7))
endpackage

// File: rtl/csa_row.sv
module csa_row #(
    parameter int unsigned W = 11
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] s_o,
    output logic [W:0]   c_o
);
    logic [W-1:0] maj;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign s_o[b] = x_i[b] ^ y_i[b] ^ z_i[b];
        assign maj[b] = (x_i[b] & y_i[b]) | (x_i[b] & z_i[b]) | (y_i[b] & z_i[b]);
    end

    // Carry weighs one place more than the bit that produced it.
    assign c_o = {maj, 1'b0};
endmodule

// File: rtl/ripple_cpa.sv
module ripple_cpa #(
    parameter int unsigned W = 11
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;

    for (genvar b = 0; b < W; b++) begin : g_fa
        assign sum_o[b] = a_i[b] ^ b_i[b] ^ cy[b];
        assign cy[b+1]  = (a_i[b] & b_i[b]) | (cy[b] & (a_i[b] ^ b_i[b]));
    end

    assign cout_o = cy[W];
endmodule

// File: rtl/csa7_tree.sv
module csa7_tree
    import csa7_pkg::*;
#(
    parameter int unsigned OPW = OPW_DEF
) (
    input  logic [OPW-1:0]   opa_i,
    input  logic [OPW-1:0]   opb_i,
    input  logic [OPW-1:0]   opc_i,
    input  logic [OPW-1:0]   opd_i,
    input  logic [OPW-1:0]   ope_i,
    input  logic [OPW-1:0]   opf_i,
    input  logic [OPW-1:0]   opg_i,
    output logic [OPW+2:0]   sum_o
);
    localparam int unsigned SW = OPW + GROWTH;

    // Zero-extended operands at the full sum width.
    logic [N_OPS-1:0][SW-1:0]  opx;

    // Row wiring: inputs, partial sums, full-width carries, truncated carries.
    logic [N_ROWS-1:0][SW-1:0] rx;
    logic [N_ROWS-1:0][SW-1:0] ry;
    logic [N_ROWS-1:0][SW-1:0] rz;
    logic [N_ROWS-1:0][SW-1:0] rs;
    logic [N_ROWS-1:0][SW:0]   rc_full;
    logic [N_ROWS-1:0][SW-1:0] rc;

    logic                      cpa_cout;

    assign opx[0] = {{GROWTH{1'b0}}, opa_i};
    assign opx[1] = {{GROWTH{1'b0}}, opb_i};
    assign opx[2] = {{GROWTH{1'b0}}, opc_i};
    assign opx[3] = {{GROWTH{1'b0}}, opd_i};
    assign opx[4] = {{GROWTH{1'b0}}, ope_i};
    assign opx[5] = {{GROWTH{1'b0}}, opf_i};
    assign opx[6] = {{GROWTH{1'b0}}, opg_i};

    // Wallace schedule, seven vectors down to two:
    //   level 1: row0(A,B,C)  row1(D,E,F)        -> s0 c0 s1 c1 G
    //   level 2: row2(s0,c0,s1)                  -> s2 c2 c1 G
    //   level 3: row3(s2,c2,c1)                  -> s3 c3 G
    //   level 4: row4(s3,c3,G)                   -> s4 c4
    always_comb begin
        rx[0] = opx[0]; ry[0] = opx[1]; rz[0] = opx[2];
        rx[1] = opx[3]; ry[1] = opx[4]; rz[1] = opx[5];
        rx[2] = rs[0];  ry[2] = rc[0];  rz[2] = rs[1];
        rx[3] = rs[2];  ry[3] = rc[2];  rz[3] = rc[1];
        rx[4] = rs[3];  ry[4] = rc[3];  rz[4] = opx[6];
    end

    for (genvar k = 0; k < N_ROWS; k++) begin : g_row
        csa_row #(.W(SW)) u_row (
            .x_i (rx[k]),
            .y_i (ry[k]),
            .z_i (rz[k]),
            .s_o (rs[k]),
            .c_o (rc_full[k])
        );
        // Top bit is provably zero since no total exceeds the SW-bit range.
        assign rc[k] = rc_full[k][SW-1:0];
    end

    ripple_cpa #(.W(SW)) u_cpa (
        .a_i    (rs[N_ROWS-1]),
        .b_i    (rc[N_ROWS-1]),
        .sum_o  (sum_o),
        .cout_o (cpa_cout)
    );
endmodule

// File: rtl/csa7_chk.sv
module csa7_chk #(
    parameter int unsigned OPW = 8
) (
    input logic [OPW-1:0]        opa_i,
    input logic [OPW-1:0]        opb_i,
    input logic [OPW-1:0]        opc_i,
    input logic [OPW-1:0]        opd_i,
    input logic [OPW-1:0]        ope_i,
    input logic [OPW-1:0]        opf_i,
    input logic [OPW-1:0]        opg_i,
    input logic [OPW+2:0]        sum_o,
    input logic [4:0][OPW+2:0]   rx,
    input logic [4:0][OPW+2:0]   ry,
    input logic [4:0][OPW+2:0]   rz,
    input logic [4:0][OPW+2:0]   rs,
    input logic [4:0][OPW+3:0]   rc_full,
    input logic                  cpa_cout
);
    localparam int unsigned SW = OPW + 3;

    logic [SW+1:0] ref_total;
    logic          all_ones;

    assign ref_total = (SW+2)'(opa_i) + (SW+2)'(opb_i) + (SW+2)'(opc_i)
                     + (SW+2)'(opd_i) + (SW+2)'(ope_i) + (SW+2)'(opf_i)
                     + (SW+2)'(opg_i);
    assign all_ones  = &{opa_i, opb_i, opc_i, opd_i, ope_i, opf_i, opg_i};

    always_comb begin
        p_sum_matches_r1: assert ((SW+2)'(sum_o) == ref_total)
            else $error("R1 sum %0d ref %0d", sum_o, ref_total);
        p_all_ones_r2: assert (!all_ones || sum_o == SW'(1785))
            else $error("R2 all-ones sum %0d", sum_o);
        p_no_overflow_r3: assert (!cpa_cout)
            else $error("R3 final adder carry-out set");
        p_zero_r5: assert ((|{opa_i, opb_i, opc_i, opd_i, ope_i, opf_i, opg_i}) || sum_o == '0)
            else $error("R5 zero operands gave %0d", sum_o);
    end

    for (genvar k = 0; k < 5; k++) begin : g_rowchk
        always_comb begin
            p_row_msb_r3: assert (!rc_full[k][SW])
                else $error("R3 row %0d carry beyond sum width", k);
            p_row_conserve_r4: assert ((SW+2)'(rx[k]) + (SW+2)'(ry[k]) + (SW+2)'(rz[k])
                                       == (SW+2)'(rs[k]) + (SW+2)'(rc_full[k]))
                else $error("R4 row %0d loses value", k);
        end
    end
endmodule

bind csa7_tree csa7_chk #(.OPW(OPW)) u_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .opc_i    (opc_i),
    .opd_i    (opd_i),
    .ope_i    (ope_i),
    .opf_i    (opf_i),
    .opg_i    (opg_i),
    .sum_o    (sum_o),
    .rx       (rx),
    .ry       (ry),
    .rz       (rz),
    .rs       (rs),
    .rc_full  (rc_full),
    .cpa_cout (cpa_cout)
);

// File: tb/sim_csa7_tree.sv
module sim_csa7_tree;
    localparam int CLK_PERIOD = 10;
    localparam int OPW        = 8;
    localparam int SW         = OPW + 3;

    logic          clk = 1'b0;
    logic [OPW-1:0] ops [7];
    logic [SW-1:0] sum_o;
    int            n_vec  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csa7_tree #(.OPW(OPW)) u0 (
        .opa_i (ops[0]),
        .opb_i (ops[1]),
        .opc_i (ops[2]),
        .opd_i (ops[3]),
        .ope_i (ops[4]),
        .opf_i (ops[5]),
        .opg_i (ops[6]),
        .sum_o (sum_o)
    );

    function automatic int ref_sum();
        int t = 0;
        for (int i = 0; i < 7; i++) t += int'(ops[i]);
        return t;
    endfunction

    // Drive at a falling edge, sample mid-phase; no rising edge is needed (R8).
    task automatic apply_check(input string req, input int expect_v);
        @(negedge clk);
        #1;
        n_vec++;
        if (int'(sum_o) != expect_v) begin
            n_fail++;
            $display("FAIL %s: sum_o=%0d expected=%0d", req, sum_o, expect_v);
        end
    endtask

    task automatic clear_ops();
        for (int i = 0; i < 7; i++) ops[i] = '0;
    endtask

    task automatic t_zero();   // R5
        clear_ops();
        apply_check("R5", 0);
    endtask

    task automatic t_all_ones();   // R2
        for (int i = 0; i < 7; i++) ops[i] = 8'hFF;
        apply_check("R2", 1785);
    endtask

    task automatic t_single();   // R6 each position, several values
        int vals [4] = '{1, 8'h80, 8'hFF, 8'h5A};
        for (int p = 0; p < 7; p++) begin
            for (int v = 0; v < 4; v++) begin
                clear_ops();
                ops[p] = OPW'(vals[v]);
                apply_check("R6", vals[v]);
            end
        end
    endtask

    task automatic t_three();   // R7
        clear_ops();
        ops[0] = 8'd200; ops[1] = 8'd100; ops[2] = 8'd255;
        apply_check("R7", 555);
        clear_ops();
        ops[1] = 8'hFF; ops[4] = 8'hFF; ops[6] = 8'hFF;
        apply_check("R7", 765);
    endtask

    task automatic t_high_patterns();   // R3 deep carries
        for (int i = 0; i < 7; i++) ops[i] = (i % 2 == 0) ? 8'hAA : 8'h55;
        apply_check("R3", 4*170 + 3*85);
        for (int i = 0; i < 7; i++) ops[i] = 8'hFE;
        apply_check("R3", 7*254);
        for (int i = 0; i < 7; i++) ops[i] = 8'hFF;
        ops[6] = 8'hFE;
        apply_check("R3", 6*255 + 254);
    endtask

    task automatic t_random();   // R1, R4 through the total
        for (int n = 0; n < 2000; n++) begin
            for (int i = 0; i < 7; i++) ops[i] = OPW'($urandom);
            apply_check("R1", ref_sum());
        end
    endtask

    task automatic t_comb_update();   // R8: change without waiting a full cycle
        clear_ops();
        ops[3] = 8'd9;
        #1;
        ops[5] = 8'd30;
        #1;
        n_vec++;
        if (int'(sum_o) != 39) begin
            n_fail++;
            $display("FAIL R8: sum_o=%0d expected=%0d", sum_o, 39);
        end
    endtask

    initial begin
        clear_ops();
        #1;
        n_vec++;
        if (sum_o != '0) begin
            n_fail++;
            $display("FAIL R5: initial sum_o=%0d expected=0", sum_o);
        end
        void'($urandom(32'h1F2E3D4C));
        t_zero();
        t_all_ones();
        t_single();
        t_three();
        t_high_patterns();
        t_comb_update();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule